// File: doc/BRIEF.md
# Register-format integer execute unit

This block is the execute stage for register-to-register instructions in a small 32-bit load/store processor. It receives the two source register values, the 5-bit shift-amount field and the 6-bit function field of a decoded instruction. It returns the 32-bit result that writeback will store. It also returns a flag that marks a function code the unit does not implement.

The function field selects the operation directly. There is no intermediate ALU opcode. The unit covers:
- wrapping add and subtract,
- OR, XOR and NOR,
- a logical left shift and an arithmetic right shift.

Both shifts act on the second operand and take their distance from the shift-amount field. The first operand plays no part in a shift. The unit is purely combinational, so the surrounding pipeline decides where the registers go.

Top module: `exec_rtype_unit`

## Requirements
- R1: With func_i = 6'h21, result_o equals rs_i + rt_i modulo 2^32, with no overflow indication, and illegal_o is 0.
- R2: With func_i = 6'h23, result_o equals rs_i - rt_i modulo 2^32, wrapping when rt_i > rs_i, and illegal_o is 0.
- R3: With func_i = 6'h25, result_o is the bitwise OR of rs_i and rt_i.
- R4: With func_i = 6'h26, result_o is the bitwise XOR of rs_i and rt_i.
- R5: With func_i = 6'h27, result_o is the bitwise complement of (rs_i | rt_i).
- R6: With func_i = 6'h00, result_o is rt_i shifted left by shamt_i with zeros entering at bit 0. A distance of 6 equals rt_i * 64 modulo 2^32.
- R7: With func_i = 6'h03, result_o is rt_i shifted right by shamt_i, and copies of rt_i[31] enter at bit 31.
- R8: For both shift codes, the value of rs_i has no effect on result_o.
- R9: For both shift codes, shamt_i = 0 gives result_o = rt_i. shamt_i = 31 is the largest distance.
- R10: Any func_i other than 6'h00, 6'h03, 6'h21, 6'h23, 6'h25, 6'h26 and 6'h27 gives result_o = 0 and illegal_o = 1. Every listed code gives illegal_o = 0.
- R11: The unit holds no state. result_o and illegal_o follow the current inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_i | input | 32 | First source operand |
| rt_i | input | 32 | Second source operand; the value that is shifted |
| shamt_i | input | 5 | Shift distance for the two shift codes |
| func_i | input | 6 | Function field that selects the operation |
| result_o | output | 32 | Operation result |
| illegal_o | output | 1 | High for an unimplemented function code |

## Verification
Every result and the illegal flag are due in the same cycle as the inputs that produce them, because the path holds no register. The bench changes the inputs just after a rising edge and compares both outputs at the following falling edge. It uses a behavioural reference model that knows nothing of the RTL's structure. The rs-independence of the shifts is checked by applying the same rt and distance twice with different rs values and comparing the two sampled outputs, each sampled half a period after its own stimulus.

// File: rtl/exec_rtype_pkg.sv
package exec_rtype_pkg;

  localparam int unsigned FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNC_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FUNC_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FUNC_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
  localparam logic [FUNC_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FUNC_W-1:0] FN_NOR  = 6'h27;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_SUB,
    OP_OR,
    OP_XOR,
    OP_NOR,
    OP_SLL,
    OP_SRA,
    OP_BAD
  } exec_op_e;

endpackage

// File: rtl/exec_rtype_decode.sv
module exec_rtype_decode
  import exec_rtype_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output exec_op_e          op_o,
  output logic              bad_o
);

  always_comb begin
    unique case (func_i)
      FN_ADDU: op_o = OP_ADD;
      FN_SUBU: op_o = OP_SUB;
      FN_OR:   op_o = OP_OR;
      FN_XOR:  op_o = OP_XOR;
      FN_NOR:  op_o = OP_NOR;
      FN_SLL:  op_o = OP_SLL;
      FN_SRA:  op_o = OP_SRA;
      default: op_o = OP_BAD;
    endcase
  end

  assign bad_o = (op_o == OP_BAD);

endmodule

// File: rtl/exec_rtype_addsub.sv
module exec_rtype_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);

  // a + ~b + 1 for subtract; carry out dropped (no overflow detection)
  logic [DATA_W-1:0] b_eff;

  assign b_eff = b_i ^ {DATA_W{sub_i}};
  assign sum_o = a_i + b_eff + DATA_W'(sub_i);

endmodule

// File: rtl/exec_rtype_logic.sv
module exec_rtype_logic
  import exec_rtype_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  exec_op_e          op_i,
  output logic [DATA_W-1:0] res_o
);

  logic [DATA_W-1:0] or_v;

  assign or_v = a_i | b_i;

  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = or_v;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOR:  res_o = ~or_v;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/exec_rtype_shift.sv
module exec_rtype_shift #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = 5,
  parameter bit          LEFT    = 1'b1
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               fill_i,
  output logic [DATA_W-1:0]  data_o
);

  // log2 barrel: stage k moves by 2^k when shamt_i[k] is set
  logic [SHAMT_W:0][DATA_W-1:0] stage;

  assign stage[0] = data_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    if (LEFT) begin : g_left
      assign stage[k+1] = shamt_i[k]
                          ? {stage[k][DATA_W-1-DIST:0], {DIST{fill_i}}}
                          : stage[k];
    end else begin : g_right
      assign stage[k+1] = shamt_i[k]
                          ? {{DIST{fill_i}}, stage[k][DATA_W-1:DIST]}
                          : stage[k];
    end
  end

  assign data_o = stage[SHAMT_W];

endmodule

// File: rtl/exec_rtype_unit.sv
module exec_rtype_unit
  import exec_rtype_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  rs_i,
  input  logic [DATA_W-1:0]  rt_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [FUNC_W-1:0]  func_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               illegal_o
);

  exec_op_e          op;
  logic              bad;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] sll_res;
  logic [DATA_W-1:0] sra_res;

  exec_rtype_decode i_decode (
    .func_i (func_i),
    .op_o   (op),
    .bad_o  (bad)
  );

  exec_rtype_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i   (rs_i),
    .b_i   (rt_i),
    .sub_i (op == OP_SUB),
    .sum_o (arith_res)
  );

  exec_rtype_logic #(.DATA_W(DATA_W)) i_logic (
    .a_i   (rs_i),
    .b_i   (rt_i),
    .op_i  (op),
    .res_o (logic_res)
  );

  exec_rtype_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b1)) i_sll (
    .data_i  (rt_i),
    .shamt_i (shamt_i),
    .fill_i  (1'b0),
    .data_o  (sll_res)
  );

  exec_rtype_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b0)) i_sra (
    .data_i  (rt_i),
    .shamt_i (shamt_i),
    .fill_i  (rt_i[DATA_W-1]),
    .data_o  (sra_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:        result_o = arith_res;
      OP_OR, OP_XOR, OP_NOR: result_o = logic_res;
      OP_SLL:                result_o = sll_res;
      OP_SRA:                result_o = sra_res;
      default:               result_o = '0;
    endcase
  end

  assign illegal_o = bad;

endmodule

// File: rtl/exec_rtype_checker.sv
module exec_rtype_checker
  import exec_rtype_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  rs_i,
  input logic [DATA_W-1:0]  rt_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [FUNC_W-1:0]  func_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               illegal_o
);

  logic [DATA_W-1:0] low_mask;
  logic              is_shift;
  logic              is_known;

  assign low_mask = ~({DATA_W{1'b1}} << shamt_i);
  assign is_shift = (func_i == FN_SLL) || (func_i == FN_SRA);
  assign is_known = is_shift || (func_i == FN_ADDU) || (func_i == FN_SUBU) ||
                    (func_i == FN_OR) || (func_i == FN_XOR) || (func_i == FN_NOR);

  always_comb begin
    if (func_i == FN_ADDU)
      AST_ADD_INVERTS: assert ((result_o - rt_i) == rs_i) else $error("add inverse"); // R1
    if (func_i == FN_SUBU)
      AST_SUB_INVERTS: assert ((result_o + rt_i) == rs_i) else $error("sub inverse"); // R2
    if (func_i == FN_XOR)
      AST_XOR_INVERTS: assert ((result_o ^ rt_i) == rs_i) else $error("xor inverse"); // R4
    if (func_i == FN_NOR)
      AST_NOR_DISJOINT: assert (((result_o & rs_i) == '0) && ((result_o | rs_i | rt_i) == '1))
        else $error("nor partition"); // R5
    if (func_i == FN_SLL)
      AST_SLL_LOW_ZERO: assert ((result_o & low_mask) == '0) else $error("sll fill"); // R6
    if (func_i == FN_SRA)
      AST_SRA_KEEPS_SIGN: assert (result_o[DATA_W-1] == rt_i[DATA_W-1]) else $error("sra sign"); // R7
    if (is_shift && (shamt_i == '0))
      AST_SHIFT_ZERO_PASS: assert (result_o == rt_i) else $error("zero shift"); // R9
    if (!is_known)
      AST_BAD_ZERO: assert (illegal_o && (result_o == '0)) else $error("bad code"); // R10
    if (is_known)
      AST_KNOWN_LEGAL: assert (!illegal_o) else $error("legal flagged"); // R10
  end

endmodule

bind exec_rtype_unit exec_rtype_checker #(.DATA_W(DATA_W)) i_exec_rtype_checker (
  .rs_i      (rs_i),
  .rt_i      (rt_i),
  .shamt_i   (shamt_i),
  .func_i    (func_i),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/test_exec_rtype_unit.sv
module test_exec_rtype_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_RAND     = 200;

  logic        clk = 1'b0;
  logic [31:0] rs, rt;
  logic [4:0]  shamt;
  logic [5:0]  func;
  logic [31:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_rtype_unit i_exec_rtype_unit (
    .rs_i      (rs),
    .rt_i      (rt),
    .shamt_i   (shamt),
    .func_i    (func),
    .result_o  (result),
    .illegal_o (illegal)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic is_legal(logic [5:0] f);
    return f inside {6'h00, 6'h03, 6'h21, 6'h23, 6'h25, 6'h26, 6'h27};
  endfunction

  function automatic logic [31:0] model(logic [5:0] f, logic [31:0] a, logic [31:0] b,
                                        logic [4:0] s);
    case (f)
      6'h21:   return a + b;
      6'h23:   return a - b;
      6'h25:   return a | b;
      6'h26:   return a ^ b;
      6'h27:   return ~(a | b);
      6'h00:   return b << s;
      6'h03:   return $unsigned($signed(b) >>> s);
      default: return 32'h0;
    endcase
  endfunction

  // drive after a rising edge, sample at the following falling edge (zero latency)
  task automatic apply(logic [5:0] f, logic [31:0] a, logic [31:0] b, logic [4:0] s);
    @(posedge clk);
    #1;
    func = f; rs = a; rt = b; shamt = s;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] exp_res, logic exp_ill);
    checks++;
    if (result !== exp_res || illegal !== exp_ill) begin
      errors++;
      $display("FAIL %s func=%h rs=%h rt=%h sh=%0d: act=%h/%b exp=%h/%b",
               req, func, rs, rt, shamt, result, illegal, exp_res, exp_ill);
    end
  endtask

  task automatic run(string req, logic [5:0] f, logic [31:0] a, logic [31:0] b,
                     logic [4:0] s);
    apply(f, a, b, s);
    check(req, model(f, a, b, s), !is_legal(f));
  endtask

  initial begin
    logic [31:0] first;
    rs = '0; rt = '0; shamt = '0; func = '0;
    @(negedge clk);
    check("R11 initial", 32'h0, 1'b0);

    // R1 directed and random
    run("R1 wrap", 6'h21, 32'hFFFF_FFFF, 32'h0000_0002, 5'd0);
    run("R1 max", 6'h21, 32'h7FFF_FFFF, 32'h0000_0001, 5'd3);
    // R2
    run("R2 borrow", 6'h23, 32'h0000_0001, 32'h0000_0002, 5'd0);
    run("R2 equal", 6'h23, 32'h1234_5678, 32'h1234_5678, 5'd9);
    // R3 R4 R5
    run("R3 or", 6'h25, 32'hF0F0_0000, 32'h0000_0F0F, 5'd0);
    run("R4 xor", 6'h26, 32'hAAAA_5555, 32'hFFFF_0000, 5'd0);
    run("R5 nor zero", 6'h27, 32'h0, 32'h0, 5'd0);
    // R6
    run("R6 times64", 6'h00, 32'h0000_0003, 32'h0000_0005, 5'd6);
    if (result !== 32'h0000_0005 * 32'd64) begin
      errors++;
      $display("FAIL R6 x64: act=%h exp=%h", result, 32'h0000_0140);
    end
    checks++;
    run("R6 max", 6'h00, 32'h0, 32'hFFFF_FFFF, 5'd31);
    // R7
    run("R7 neg", 6'h03, 32'h0, 32'h8000_0000, 5'd31);
    run("R7 pos", 6'h03, 32'h0, 32'h7FFF_FFFF, 5'd31);
    run("R7 mid", 6'h03, 32'h0, 32'hF000_00F0, 5'd4);
    // R9
    run("R9 sll zero", 6'h00, 32'hDEAD_BEEF, 32'h8765_4321, 5'd0);
    run("R9 sra zero", 6'h03, 32'hDEAD_BEEF, 32'h8765_4321, 5'd0);

    // R8: rs must not change a shift result
    for (int i = 0; i < 20; i++) begin
      logic [31:0] t;
      logic [4:0]  s;
      logic [5:0]  f;
      t = $urandom; s = 5'($urandom); f = (i % 2 == 0) ? 6'h00 : 6'h03;
      apply(f, 32'h0, t, s);
      first = result;
      apply(f, $urandom, t, s);
      checks++;
      if (result !== first) begin
        errors++;
        $display("FAIL R8 rs affects shift: act=%h exp=%h", result, first);
      end
    end

    // R10: every unlisted code
    for (int c = 0; c < 64; c++) begin
      if (!is_legal(6'(c))) run("R10 bad code", 6'(c), $urandom, $urandom, 5'($urandom));
    end

    // R1..R7 random sweep, every legal code
    for (int i = 0; i < N_RAND; i++) begin
      run("R1 rand", 6'h21, $urandom, $urandom, 5'($urandom));
      run("R2 rand", 6'h23, $urandom, $urandom, 5'($urandom));
      run("R3 rand", 6'h25, $urandom, $urandom, 5'($urandom));
      run("R4 rand", 6'h26, $urandom, $urandom, 5'($urandom));
      run("R5 rand", 6'h27, $urandom, $urandom, 5'($urandom));
      run("R6 rand", 6'h00, $urandom, $urandom, 5'($urandom));
      run("R7 rand", 6'h03, $urandom, $urandom, 5'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule